// File: doc/BRIEF.md
# Pipe-Stage Adder Self-Test Wrapper

This block wraps one combinational unit of a pipeline stage (here a ripple-carry adder with carry in and carry out) with built-in self-test logic. It lets that unit be tested online while the processor runs normal code. A test instruction issued in place of a pipeline bubble marks a cycle with the stage's valid and test flags both high. In that cycle the unit's operands come from a linear feedback shift register instead of the functional datapath. The unit's full response word is folded into a parallel signature register within the same clock.

In every other cycle the unit sees its functional operands, and both the pattern generator and the signature hold. Test cycles can therefore be scattered freely between ordinary instructions without disturbing either side. A synchronous clear restarts a test run. A check request compares the accumulated signature with a precomputed expected constant and reports good or faulty on the following cycle.

Top module: `stage_bist_wrap`

## Requirements
- R1: While rst_ni is low, signature_o is 0, check_done_o and check_pass_o are 0, and the pattern register holds LFSR_SEED.
- R2: In a test cycle (stage_valid_i and stage_test_i both 1), the unit inputs come from the pattern register P: unit_a_o = P[DATA_W-1:0], unit_b_o = P[2*DATA_W-1:DATA_W], unit_cin_o = P[0] xor P[LFSR_W-1].
- R3: In any other cycle, including a test flag without valid and valid without test, unit_a_o, unit_b_o and unit_cin_o equal op_a_i, op_b_i and op_cin_i.
- R4: At the end of each test cycle P shifts one place toward its MSB, and the parity of (P and LFSR_TAPS) enters bit 0. P holds in all other cycles.
- R5: At the end of each test cycle the signature S becomes (S·x mod MISR_POLY with the implicit x^(DATA_W+1) term) xor {cout_o, sum_o}. Bit 0 of the response is sum bit 0 and the top bit is the carry. S holds in all other cycles.
- R6: bist_clear_i loads LFSR_SEED into P and 0 into S at the next edge, taking precedence over a test cycle in the same cycle.
- R7: One cycle after sig_check_i is sampled high, check_done_o is 1 for exactly that cycle. check_pass_o then shows whether S at the request equalled EXP_SIG, and keeps that value until the next request.
- R8: {cout_o, sum_o} always equals unit_a_o + unit_b_o + unit_cin_o.
- R9: A stuck-at-1 on one sum bit (STUCK1_MASK) gives a different signature than the fault-free unit after a run of 8192 test cycles interleaved with functional cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stage_valid_i | input | 1 | Stage holds a valid instruction |
| stage_test_i | input | 1 | Instruction in the stage is a test instruction |
| bist_clear_i | input | 1 | Synchronous restart of pattern and signature |
| op_a_i | input | DATA_W | Functional operand A |
| op_b_i | input | DATA_W | Functional operand B |
| op_cin_i | input | 1 | Functional carry in |
| sig_check_i | input | 1 | Request a signature comparison |
| unit_a_o | output | DATA_W | Operand A as applied to the unit |
| unit_b_o | output | DATA_W | Operand B as applied to the unit |
| unit_cin_o | output | 1 | Carry in as applied to the unit |
| sum_o | output | DATA_W | Unit sum |
| cout_o | output | 1 | Unit carry out |
| signature_o | output | DATA_W+1 | Current signature |
| check_done_o | output | 1 | Comparison result valid this cycle |
| check_pass_o | output | 1 | Last comparison matched EXP_SIG |

## Verification
The bench uses DATA_W = 16, a 32-bit pattern register with taps 0x80200003, and a degree-17 signature polynomial with mask 0x9. Under these values the random-pattern sum reaches both carry polarities, and an 8192-vector run becomes a practical length. EXP_SIG is set to 0, so a check straight after a clear gives a pass and a check after any real run gives the fail case. A second instance with sum bit 5 stuck at 1 receives the same stimulus, so that the signature's fault sensitivity is measured against the fault-free model.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned LFSR_W_DEF = 32;
  localparam logic [31:0] LFSR_TAPS_DEF = 32'h8020_0003;
  localparam logic [31:0] LFSR_SEED_DEF = 32'hACE1_2B5F;
  localparam logic [16:0] MISR_POLY_DEF = 17'h0_0009;

  typedef enum logic {
    SRC_FUNC = 1'b0,
    SRC_LFSR = 1'b1
  } src_sel_e;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= SEED;
    else if (clear_i) q <= SEED;
    else if (step_i)  q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign state_o = q;
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int unsigned W = 17,
  parameter logic [W-1:0] POLY = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] q, nxt;

  // whole response word folded in one edge
  always_comb nxt = {q[W-2:0], 1'b0} ^ (q[W-1] ? POLY : '0) ^ resp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (clear_i) q <= '0;
    else if (load_i)  q <= nxt;
  end

  assign sig_o = q;
endmodule

// File: rtl/bist_adder_unit.sv
module bist_adder_unit #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] STUCK1_MASK = '0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s;
    assign s        = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    assign sum_o[i] = s | STUCK1_MASK[i];
  end

  assign cout_o = c[W];
endmodule

// File: rtl/stage_bist_wrap.sv
module stage_bist_wrap
  import bist_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned LFSR_W = LFSR_W_DEF,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = LFSR_TAPS_DEF,
  parameter logic [LFSR_W-1:0] LFSR_SEED = LFSR_SEED_DEF,
  parameter logic [DATA_W:0] MISR_POLY = MISR_POLY_DEF,
  parameter logic [DATA_W:0] EXP_SIG = '0,
  parameter logic [DATA_W-1:0] STUCK1_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_valid_i,
  input  logic              stage_test_i,
  input  logic              bist_clear_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              op_cin_i,
  input  logic              sig_check_i,
  output logic [DATA_W-1:0] unit_a_o,
  output logic [DATA_W-1:0] unit_b_o,
  output logic              unit_cin_o,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic [DATA_W:0]   signature_o,
  output logic              check_done_o,
  output logic              check_pass_o
);
  localparam int unsigned RESP_W = DATA_W + 1;

  logic              test_cyc;
  src_sel_e          src;
  logic [LFSR_W-1:0] lfsr_q;
  logic [DATA_W-1:0] pat_a, pat_b;
  logic              pat_cin;
  logic [RESP_W-1:0] sig_q;
  logic              done_q, pass_q;

  assign test_cyc = stage_valid_i & stage_test_i;
  assign src      = test_cyc ? SRC_LFSR : SRC_FUNC;

  bist_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(bist_clear_i),
    .step_i (test_cyc),
    .state_o(lfsr_q)
  );

  assign pat_a   = lfsr_q[DATA_W-1:0];
  assign pat_b   = lfsr_q[2*DATA_W-1:DATA_W];
  assign pat_cin = lfsr_q[0] ^ lfsr_q[LFSR_W-1];

  always_comb begin
    unique case (src)
      SRC_LFSR: begin
        unit_a_o   = pat_a;
        unit_b_o   = pat_b;
        unit_cin_o = pat_cin;
      end
      default: begin
        unit_a_o   = op_a_i;
        unit_b_o   = op_b_i;
        unit_cin_o = op_cin_i;
      end
    endcase
  end

  bist_adder_unit #(.W(DATA_W), .STUCK1_MASK(STUCK1_MASK)) u_unit (
    .a_i   (unit_a_o),
    .b_i   (unit_b_o),
    .cin_i (unit_cin_o),
    .sum_o (sum_o),
    .cout_o(cout_o)
  );

  bist_misr #(.W(RESP_W), .POLY(MISR_POLY)) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(bist_clear_i),
    .load_i (test_cyc),
    .resp_i ({cout_o, sum_o}),
    .sig_o  (sig_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= sig_check_i;
      if (sig_check_i) pass_q <= (sig_q == EXP_SIG);
    end
  end

  assign signature_o  = sig_q;
  assign check_done_o = done_q;
  assign check_pass_o = pass_q;
endmodule

// File: rtl/stage_bist_chk.sv
module stage_bist_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LFSR_W = 32,
  parameter logic [DATA_W:0] EXP_SIG = '0,
  parameter logic [DATA_W-1:0] STUCK1_MASK = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stage_valid_i,
  input logic              stage_test_i,
  input logic              bist_clear_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              op_cin_i,
  input logic              sig_check_i,
  input logic [DATA_W-1:0] unit_a_o,
  input logic [DATA_W-1:0] unit_b_o,
  input logic              unit_cin_o,
  input logic [DATA_W-1:0] sum_o,
  input logic              cout_o,
  input logic [DATA_W:0]   signature_o,
  input logic              check_done_o,
  input logic              check_pass_o,
  input logic [LFSR_W-1:0] lfsr_i
);
  logic tst;
  assign tst = stage_valid_i && stage_test_i;

  assert_lfsr_feed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst |-> (unit_a_o == lfsr_i[DATA_W-1:0] && unit_b_o == lfsr_i[2*DATA_W-1:DATA_W]));

  assert_func_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tst |-> (unit_a_o == op_a_i && unit_b_o == op_b_i && unit_cin_o == op_cin_i));

  assert_lfsr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tst && !bist_clear_i) |=> $stable(lfsr_i));

  assert_lfsr_move_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst && !bist_clear_i) |=> (lfsr_i != $past(lfsr_i)));

  assert_sig_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tst && !bist_clear_i) |=> $stable(signature_o));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bist_clear_i |=> (signature_o == '0));

  assert_done_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_check_i |=> check_done_o);

  assert_done_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_check_i |=> !check_done_o);

  assert_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_done_o |-> (check_pass_o == ($past(signature_o) == EXP_SIG)));

  if (STUCK1_MASK == '0) begin : g_sum_chk
    assert_sum_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {cout_o, sum_o} == ({1'b0, unit_a_o} + {1'b0, unit_b_o} + {{DATA_W{1'b0}}, unit_cin_o}));
  end
endmodule

bind stage_bist_wrap stage_bist_chk #(
  .DATA_W(DATA_W), .LFSR_W(LFSR_W), .EXP_SIG(EXP_SIG), .STUCK1_MASK(STUCK1_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stage_valid_i(stage_valid_i), .stage_test_i(stage_test_i),
  .bist_clear_i(bist_clear_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .op_cin_i(op_cin_i),
  .sig_check_i(sig_check_i), .unit_a_o(unit_a_o), .unit_b_o(unit_b_o), .unit_cin_o(unit_cin_o),
  .sum_o(sum_o), .cout_o(cout_o), .signature_o(signature_o), .check_done_o(check_done_o),
  .check_pass_o(check_pass_o), .lfsr_i(lfsr_q)
);

// File: tb/stage_bist_wrap_tb_top.sv
module stage_bist_wrap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SEED = 32'hACE1_2B5F;
  localparam logic [31:0] TAPS = 32'h8020_0003;
  localparam logic [16:0] POLY = 17'h0_0009;
  localparam logic [16:0] EXP  = 17'h0;
  localparam int RUN_VECTORS = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, test = 1'b0, clr = 1'b0, chk = 1'b0, cin = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;

  logic [15:0] ua, ub, sum;
  logic uc, cout, done, pass;
  logic [16:0] sig;

  logic [15:0] ua_f, ub_f, sum_f;
  logic uc_f, cout_f, done_f, pass_f;
  logic [16:0] sig_f;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;

  // behavioural reference state
  int unsigned lfsr_m;
  int unsigned misr_m;
  bit done_m, pass_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_bist_wrap #(
    .DATA_W(16), .LFSR_W(32), .LFSR_TAPS(TAPS), .LFSR_SEED(SEED),
    .MISR_POLY(POLY), .EXP_SIG(EXP), .STUCK1_MASK(16'h0000)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stage_valid_i(valid), .stage_test_i(test),
    .bist_clear_i(clr), .op_a_i(op_a), .op_b_i(op_b), .op_cin_i(cin), .sig_check_i(chk),
    .unit_a_o(ua), .unit_b_o(ub), .unit_cin_o(uc), .sum_o(sum), .cout_o(cout),
    .signature_o(sig), .check_done_o(done), .check_pass_o(pass)
  );

  stage_bist_wrap #(
    .DATA_W(16), .LFSR_W(32), .LFSR_TAPS(TAPS), .LFSR_SEED(SEED),
    .MISR_POLY(POLY), .EXP_SIG(EXP), .STUCK1_MASK(16'h0020)
  ) dut_f (
    .clk_i(clk), .rst_ni(rst_n), .stage_valid_i(valid), .stage_test_i(test),
    .bist_clear_i(clr), .op_a_i(op_a), .op_b_i(op_b), .op_cin_i(cin), .sig_check_i(chk),
    .unit_a_o(ua_f), .unit_b_o(ub_f), .unit_cin_o(uc_f), .sum_o(sum_f), .cout_o(cout_f),
    .signature_o(sig_f), .check_done_o(done_f), .check_pass_o(pass_f)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned lfsr_adv(input int unsigned s);
    int unsigned fb = $countones(s & TAPS) % 2;
    return (s << 1) | fb;
  endfunction

  function automatic int unsigned misr_adv(input int unsigned s, input int unsigned resp);
    int unsigned t = s << 1;
    if ((t & 32'h2_0000) != 0) t = t ^ (32'h2_0000 | POLY);
    return t ^ resp;
  endfunction

  task automatic cyc(input bit v, input bit t, input bit cl, input bit ck,
                     input logic [15:0] a, input logic [15:0] b, input bit c,
                     input bit after_clear);
    bit tst;
    int unsigned ea, eb, ec, s;
    valid = v; test = t; clr = cl; chk = ck; op_a = a; op_b = b; cin = c;
    #1;
    tst = v && t;
    ea = tst ? (lfsr_m & 32'hFFFF) : a;
    eb = tst ? (lfsr_m >> 16) : b;
    ec = tst ? ((lfsr_m & 1) ^ (lfsr_m >> 31)) : c;
    check(ua == ea[15:0], tst ? "R2 R4 operand A" : "R3 operand A", ua, ea);
    check(ub == eb[15:0], tst ? "R2 R4 operand B" : "R3 operand B", ub, eb);
    check(uc == ec[0], tst ? "R2 carry in" : "R3 carry in", uc, ec);
    s = ea + eb + ec;
    check({cout, sum} == s[16:0], "R8 sum", {cout, sum}, s);
    check(sig == misr_m[16:0], after_clear ? "R6 signature" : "R5 signature", sig, misr_m);
    check(done == done_m, "R7 done", done, done_m);
    check(pass == pass_m, "R7 pass", pass, pass_m);
    @(posedge clk);
    done_m = ck;
    if (ck) pass_m = (misr_m[16:0] == EXP);
    if (cl) begin
      lfsr_m = SEED;
      misr_m = 0;
    end else if (tst) begin
      misr_m = misr_adv(misr_m, s & 32'h1_FFFF);
      lfsr_m = lfsr_adv(lfsr_m);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: run did not end in time");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int tcount;
    lfsr_m = SEED; misr_m = 0; done_m = 0; pass_m = 0;
    valid = 1'b1; test = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state, pattern register visible through test-cycle operands
    check(sig == 17'h0, "R1 signature", sig, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(pass == 1'b0, "R1 pass", pass, 0);
    check(ua == SEED[15:0], "R1 seed low", ua, SEED[15:0]);
    check(ub == SEED[31:16], "R1 seed high", ub, SEED[31:16]);
    valid = 1'b0; test = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: functional cycles in every non-test flag combination
    cyc(1, 0, 0, 0, 16'hFFFF, 16'h0001, 0, 0);
    cyc(0, 1, 0, 0, 16'h1234, 16'h4321, 1, 0);
    cyc(0, 0, 0, 0, 16'h8000, 16'h8000, 1, 0);
    // R2 R4 R5: a few test cycles, separated by holds
    cyc(1, 1, 0, 0, 16'h0, 16'h0, 0, 0);
    cyc(1, 1, 0, 0, 16'h0, 16'h0, 0, 0);
    cyc(0, 1, 0, 0, 16'hAAAA, 16'h5555, 0, 0);
    cyc(1, 0, 0, 0, 16'h0F0F, 16'hF0F0, 1, 0);
    cyc(1, 1, 0, 0, 16'h0, 16'h0, 0, 0);
    // R7: check with nonzero signature, then hold of pass
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 0, 0);
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 0, 0);
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 0, 0);
    // R6: clear together with a test cycle
    cyc(1, 1, 1, 0, 16'h0, 16'h0, 0, 0);
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 0, 1);
    cyc(1, 1, 0, 0, 16'h0, 16'h0, 0, 0);
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 0, 0);
    // restart and long interleaved run
    cyc(0, 0, 1, 0, 16'h0, 16'h0, 0, 0);
    tcount = 0;
    while (tcount < RUN_VECTORS) begin
      bit v = ($urandom % 4) != 0;
      bit t = ($urandom % 3) != 0;
      bit k = ($urandom % 97) == 0;
      if (v && t) tcount++;
      cyc(v, t, 0, k, 16'($urandom), 16'($urandom), 1'($urandom), 0);
    end
    cyc(0, 0, 0, 1, 16'h0, 16'h0, 0, 0);
    cyc(0, 0, 0, 0, 16'h0, 16'h0, 0, 0);
    // R9: stuck-at-1 on sum bit 5 must leave a different signature
    check(sig_f != misr_m[16:0], "R9 faulty signature differs", sig_f, misr_m);
    check(sig == misr_m[16:0], "R9 good signature", sig, misr_m);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule